// File: doc/BRIEF.md
# Three-Channel OSD Mix and Blanking Level Selector

This block chooses, for each of three colour channels and on every clock, the digital output level code that goes on to the drive-gain stage. Each channel takes a video sample that has already been scaled by contrast. All channels share a brightness offset, an overlay level, an output DC setting, a fast-overlay select, a blank strobe and a semi-transparency enable. Each channel also has its own overlay colour bit.

The black level is a base code plus the DC setting times a step. The DC setting is clamped to 12 steps. Outside blanking, the brightness is added on top of black, followed by one of three things:
- the video sample (normal picture),
- the overlay level for a lit overlay bit (overlay display),
- half the video sample, when semi-transparency is on and the overlay code is the reserved one.

Blanking overrides every other choice and puts all channels at a fixed drop below black. The result saturates at the top code and is registered, so it appears one clock after the inputs.

Top module: `mix_osd_blank`

## Requirements
- R1: While rst_ni is low, every channel of lvl_o reads 0.
- R2: lvl_o reflects the inputs sampled at the previous rising clock edge. A change of inputs does not alter lvl_o before the next rising edge.
- R3: The black code is BLACK_BASE + min(dc_lvl_i, 12) * DC_STEP.
- R4: With blk_i low and fblk_i low, channel k outputs black + brt_i + video sample k, where channel k occupies bits [k*VID_W +: VID_W] of vid_i.
- R5: With blk_i low, fblk_i high and no semi-transparent hit, channel k outputs black + brt_i when osd_bits_i[k] is 0. It outputs black + brt_i + osd_lvl_i * OSD_STEP when osd_bits_i[k] is 1. vid_i has no effect in this case.
- R6: A semi-transparent hit means semi_en_i high, fblk_i high, blk_i low and osd_bits_i equal to SEMI_CODE (default 3'b101: bit 0 = 1, bit 1 = 0, bit 2 = 1). On a hit, channel k outputs black + brt_i + floor(video sample k / 2).
- R7: With semi_en_i high and fblk_i high, any osd_bits_i value other than SEMI_CODE gives the R5 result. With semi_en_i low, SEMI_CODE also gives the R5 result.
- R8: With blk_i high, every channel outputs black − BLANK_DROP, or 0 if black < BLANK_DROP. This holds whatever the values of fblk_i, semi_en_i, osd_bits_i, brt_i and vid_i.
- R9: Any result above 2^OUT_W − 1 is output as 2^OUT_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vid_i | input | CH_N*VID_W | Contrast-scaled video sample per channel |
| brt_i | input | BRT_W | Brightness offset, common to all channels |
| osd_lvl_i | input | OSD_W | Overlay amplitude code |
| dc_lvl_i | input | DCL_W | Output DC setting, effective range 0..12 |
| osd_bits_i | input | CH_N | Overlay colour bit per channel |
| fblk_i | input | 1 | Fast overlay select |
| blk_i | input | 1 | Blank strobe, highest priority |
| semi_en_i | input | 1 | Semi-transparency enable |
| lvl_o | output | CH_N*OUT_W | Registered level code per channel |

## Verification
The bench builds the block with OUT_W = 9 and BLACK_BASE = 8, and leaves every other parameter at its default. With a 9-bit output, a high DC setting plus full brightness and full video goes past 511, so the R9 clamp is reached. With a base of 8, a DC setting of 0 puts black below the 20-code blanking drop, so the floor at 0 in R8 is reached. DC settings 13 to 15 are driven together with 12 to show the R3 clamp.

// File: rtl/mix_osd_pkg.sv
package mix_osd_pkg;
  typedef enum logic [1:0] {
    SEL_VIDEO = 2'd0,
    SEL_OSD   = 2'd1,
    SEL_SEMI  = 2'd2,
    SEL_BLANK = 2'd3
  } sel_e;
endpackage

// File: rtl/mix_sel_dec.sv
module mix_sel_dec
  import mix_osd_pkg::*;
#(
  parameter int CH_N = 3,
  parameter logic [CH_N-1:0] SEMI_CODE = 3'b101
) (
  input  logic            blk_i,
  input  logic            fblk_i,
  input  logic            semi_en_i,
  input  logic [CH_N-1:0] osd_bits_i,
  output sel_e            sel_o
);
  // blank beats overlay, overlay beats video
  always_comb begin
    if (blk_i)                                       sel_o = SEL_BLANK;
    else if (!fblk_i)                                sel_o = SEL_VIDEO;
    else if (semi_en_i && (osd_bits_i == SEMI_CODE)) sel_o = SEL_SEMI;
    else                                             sel_o = SEL_OSD;
  end
endmodule

// File: rtl/mix_black_gen.sv
module mix_black_gen #(
  parameter int DCL_W      = 4,
  parameter int DC_MAX     = 12,
  parameter int DC_STEP    = 8,
  parameter int BLACK_BASE = 64,
  parameter int SUM_W      = 22
) (
  input  logic [DCL_W-1:0] dc_lvl_i,
  output logic [SUM_W-1:0] black_o
);
  localparam logic [DCL_W-1:0] DC_LIM = DCL_W'(DC_MAX);

  logic [DCL_W-1:0] dc_eff;

  always_comb begin
    dc_eff  = (dc_lvl_i > DC_LIM) ? DC_LIM : dc_lvl_i;
    black_o = SUM_W'(BLACK_BASE) + SUM_W'(dc_eff) * SUM_W'(DC_STEP);
  end
endmodule

// File: rtl/mix_chan_lvl.sv
module mix_chan_lvl
  import mix_osd_pkg::*;
#(
  parameter int VID_W      = 8,
  parameter int BRT_W      = 8,
  parameter int OSD_W      = 4,
  parameter int OUT_W      = 10,
  parameter int SUM_W      = 22,
  parameter int OSD_STEP   = 16,
  parameter int BLANK_DROP = 20
) (
  input  sel_e             sel_i,
  input  logic [SUM_W-1:0] black_i,
  input  logic [BRT_W-1:0] brt_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic             osd_bit_i,
  input  logic [OSD_W-1:0] osd_lvl_i,
  output logic [OUT_W-1:0] lvl_o
);
  localparam logic [SUM_W-1:0] TOP  = SUM_W'({OUT_W{1'b1}});
  localparam logic [SUM_W-1:0] DROP = SUM_W'(BLANK_DROP);

  logic [SUM_W-1:0] lit;
  logic [SUM_W-1:0] osd_add;
  logic [SUM_W-1:0] raw;

  always_comb begin
    lit     = black_i + SUM_W'(brt_i);
    osd_add = osd_bit_i ? SUM_W'(osd_lvl_i) * SUM_W'(OSD_STEP) : '0;
    unique case (sel_i)
      SEL_BLANK: raw = (black_i >= DROP) ? (black_i - DROP) : '0;
      SEL_SEMI:  raw = lit + SUM_W'(vid_i >> 1);
      SEL_OSD:   raw = lit + osd_add;
      default:   raw = lit + SUM_W'(vid_i);
    endcase
    lvl_o = (raw > TOP) ? '1 : raw[OUT_W-1:0];
  end
endmodule

// File: rtl/mix_osd_blank.sv
module mix_osd_blank
  import mix_osd_pkg::*;
#(
  parameter int CH_N       = 3,
  parameter int VID_W      = 8,
  parameter int BRT_W      = 8,
  parameter int OSD_W      = 4,
  parameter int DCL_W      = 4,
  parameter int OUT_W      = 10,
  parameter int DC_MAX     = 12,
  parameter int DC_STEP    = 8,
  parameter int BLACK_BASE = 64,
  parameter int OSD_STEP   = 16,
  parameter int BLANK_DROP = 20,
  parameter logic [CH_N-1:0] SEMI_CODE = 3'b101
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CH_N*VID_W-1:0] vid_i,
  input  logic [BRT_W-1:0]      brt_i,
  input  logic [OSD_W-1:0]      osd_lvl_i,
  input  logic [DCL_W-1:0]      dc_lvl_i,
  input  logic [CH_N-1:0]       osd_bits_i,
  input  logic                  fblk_i,
  input  logic                  blk_i,
  input  logic                  semi_en_i,
  output logic [CH_N*OUT_W-1:0] lvl_o
);
  localparam int SUM_W = OUT_W + VID_W + 4;

  sel_e             sel;
  logic [SUM_W-1:0] black;
  logic [CH_N*OUT_W-1:0] lvl_d, lvl_q;

  mix_sel_dec #(.CH_N(CH_N), .SEMI_CODE(SEMI_CODE)) u_sel (
    .blk_i      (blk_i),
    .fblk_i     (fblk_i),
    .semi_en_i  (semi_en_i),
    .osd_bits_i (osd_bits_i),
    .sel_o      (sel)
  );

  mix_black_gen #(
    .DCL_W(DCL_W), .DC_MAX(DC_MAX), .DC_STEP(DC_STEP),
    .BLACK_BASE(BLACK_BASE), .SUM_W(SUM_W)
  ) u_black (
    .dc_lvl_i (dc_lvl_i),
    .black_o  (black)
  );

  for (genvar k = 0; k < CH_N; k++) begin : g_ch
    mix_chan_lvl #(
      .VID_W(VID_W), .BRT_W(BRT_W), .OSD_W(OSD_W), .OUT_W(OUT_W),
      .SUM_W(SUM_W), .OSD_STEP(OSD_STEP), .BLANK_DROP(BLANK_DROP)
    ) u_lvl (
      .sel_i     (sel),
      .black_i   (black),
      .brt_i     (brt_i),
      .vid_i     (vid_i[k*VID_W +: VID_W]),
      .osd_bit_i (osd_bits_i[k]),
      .osd_lvl_i (osd_lvl_i),
      .lvl_o     (lvl_d[k*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/mix_osd_blank_chk.sv
module mix_osd_blank_chk #(
  parameter int CH_N  = 3,
  parameter int VID_W = 8,
  parameter int BRT_W = 8,
  parameter int OSD_W = 4,
  parameter int DCL_W = 4,
  parameter int OUT_W = 10,
  parameter logic [CH_N-1:0] SEMI_CODE = 3'b101
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [CH_N*VID_W-1:0] vid_i,
  input logic [BRT_W-1:0]      brt_i,
  input logic [OSD_W-1:0]      osd_lvl_i,
  input logic [DCL_W-1:0]      dc_lvl_i,
  input logic [CH_N-1:0]       osd_bits_i,
  input logic                  fblk_i,
  input logic                  blk_i,
  input logic                  semi_en_i,
  input logic [CH_N*OUT_W-1:0] lvl_o
);
  localparam int IN_W = CH_N*VID_W + BRT_W + OSD_W + DCL_W + CH_N + 3;

  logic [IN_W-1:0] in_now, in_q1, in_q2;
  logic [1:0] cnt;
  logic p_blk, p_fblk, p_hit, p_vid_eq, p_bit_eq;
  logic [OUT_W-1:0] ch0, ch1;

  assign in_now = {vid_i, brt_i, osd_lvl_i, dc_lvl_i, osd_bits_i, fblk_i, blk_i, semi_en_i};
  assign ch0 = lvl_o[0 +: OUT_W];
  assign ch1 = lvl_o[OUT_W +: OUT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0; in_q1 <= '0; in_q2 <= '0;
      p_blk <= 1'b0; p_fblk <= 1'b0; p_hit <= 1'b0;
      p_vid_eq <= 1'b0; p_bit_eq <= 1'b0;
    end else begin
      if (cnt != 2'd3) cnt <= cnt + 2'd1;
      in_q1 <= in_now;
      in_q2 <= in_q1;
      p_blk <= blk_i;
      p_fblk <= fblk_i;
      p_hit <= semi_en_i && fblk_i && (osd_bits_i == SEMI_CODE);
      p_vid_eq <= (vid_i[0 +: VID_W] == vid_i[VID_W +: VID_W]);
      p_bit_eq <= (osd_bits_i[0] == osd_bits_i[1]);
    end
  end

  assert_blank_uniform_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != 2'd0 && p_blk) |-> (ch0 == ch1));

  assert_video_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != 2'd0 && !p_blk && !p_fblk && p_vid_eq) |-> (ch0 == ch1));

  assert_osd_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != 2'd0 && !p_blk && p_fblk && !p_hit && p_bit_eq) |-> (ch0 == ch1));

  assert_semi_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != 2'd0 && !p_blk && p_hit && p_vid_eq) |-> (ch0 == ch1));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt >= 2'd2 && in_q1 == in_q2) |-> $stable(lvl_o));
endmodule

bind mix_osd_blank mix_osd_blank_chk #(
  .CH_N(CH_N), .VID_W(VID_W), .BRT_W(BRT_W), .OSD_W(OSD_W),
  .DCL_W(DCL_W), .OUT_W(OUT_W), .SEMI_CODE(SEMI_CODE)
) u_chk (.*);

// File: tb/mix_osd_blank_test.sv
`timescale 1ns/1ps
module mix_osd_blank_test;
  localparam int CH = 3, VW = 8, BW = 8, OW = 4, DW = 4, OUTW = 9;
  localparam int BB = 8, DCS = 8, DROP = 20, OSS = 16, DCMAX = 12;
  localparam int OMAX = (1 << OUTW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CH*VW-1:0] vid_i = '0;
  logic [BW-1:0] brt_i = '0;
  logic [OW-1:0] osd_lvl_i = '0;
  logic [DW-1:0] dc_lvl_i = '0;
  logic [CH-1:0] osd_bits_i = '0;
  logic fblk_i = 1'b0, blk_i = 1'b0, semi_en_i = 1'b0;
  logic [CH*OUTW-1:0] lvl_o;

  int tests = 0, fails = 0;
  int prev_e [CH];
  bit have_prev = 0;

  always #2.5 clk = ~clk;

  mix_osd_blank #(.OUT_W(OUTW), .BLACK_BASE(BB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .vid_i(vid_i), .brt_i(brt_i),
    .osd_lvl_i(osd_lvl_i), .dc_lvl_i(dc_lvl_i), .osd_bits_i(osd_bits_i),
    .fblk_i(fblk_i), .blk_i(blk_i), .semi_en_i(semi_en_i), .lvl_o(lvl_o)
  );

  function automatic int ref_lvl(int k);
    int dce, blk_lvl, r, v;
    dce = (int'(dc_lvl_i) > DCMAX) ? DCMAX : int'(dc_lvl_i);
    blk_lvl = BB + dce * DCS;
    v = int'(vid_i[k*VW +: VW]);
    if (blk_i) r = (blk_lvl >= DROP) ? blk_lvl - DROP : 0;
    else if (!fblk_i) r = blk_lvl + int'(brt_i) + v;
    else if (semi_en_i && osd_bits_i == 3'b101) r = blk_lvl + int'(brt_i) + v / 2;
    else r = blk_lvl + int'(brt_i) + (osd_bits_i[k] ? int'(osd_lvl_i) * OSS : 0);
    return (r > OMAX) ? OMAX : r;
  endfunction

  function automatic string mode_tag();
    if (blk_i) return "R8";
    if (!fblk_i) return "R4";
    if (semi_en_i && osd_bits_i == 3'b101) return "R6";
    if (semi_en_i) return "R7";
    return "R5";
  endfunction

  task automatic check(string tag, int k, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, k, act, exp);
    end
  endtask

  // called at a negedge: drive, confirm hold, then check after the next edge
  task automatic step(string tag);
    int e [CH];
    string t;
    t = (tag == "") ? mode_tag() : tag;
    for (int k = 0; k < CH; k++) e[k] = ref_lvl(k);
    #1;
    if (have_prev)
      for (int k = 0; k < CH; k++) check("R2", k, int'(lvl_o[k*OUTW +: OUTW]), prev_e[k]);
    @(negedge clk);
    for (int k = 0; k < CH; k++) begin
      check(t, k, int'(lvl_o[k*OUTW +: OUTW]), e[k]);
      if (e[k] == OMAX && t != "R8") check("R9", k, int'(lvl_o[k*OUTW +: OUTW]), OMAX);
      prev_e[k] = e[k];
    end
    have_prev = 1;
  endtask

  task automatic set_vid(int a, int b, int c);
    vid_i = {VW'(c), VW'(b), VW'(a)};
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int dc12 [CH];
    void'($urandom(32'd7141));
    set_vid(200, 150, 90); brt_i = 8'd40; dc_lvl_i = 4'd5;
    repeat (3) @(negedge clk);
    for (int k = 0; k < CH; k++) check("R1", k, int'(lvl_o[k*OUTW +: OUTW]), 0);
    rst_n = 1'b1;
    @(negedge clk);

    step("R4");                                          // video path
    fblk_i = 1; osd_bits_i = 3'b011; osd_lvl_i = 4'd9; step("R5");
    osd_bits_i = 3'b100; set_vid(1, 2, 3); step("R5");   // video ignored
    semi_en_i = 1; osd_bits_i = 3'b101; set_vid(201, 77, 254); step("R6");
    osd_bits_i = 3'b111; step("R7");
    semi_en_i = 0; osd_bits_i = 3'b101; step("R7");
    blk_i = 1; semi_en_i = 1; step("R8");                // blank over everything
    dc_lvl_i = 4'd0; step("R8");                         // 8 - 20 floors at 0
    blk_i = 0; fblk_i = 0; semi_en_i = 0;
    dc_lvl_i = 4'd12; set_vid(0, 0, 0); brt_i = 0; step("R3");
    for (int k = 0; k < CH; k++) dc12[k] = prev_e[k];
    for (int d = 13; d < 16; d++) begin
      dc_lvl_i = DW'(d); step("R3");
      for (int k = 0; k < CH; k++) check("R3", k, int'(lvl_o[k*OUTW +: OUTW]), dc12[k]);
    end
    brt_i = 8'd255; set_vid(255, 255, 10); step("R9");

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 8;
      blk_i = (r == 0);
      fblk_i = (r >= 4);
      semi_en_i = $urandom % 2;
      osd_bits_i = ($urandom % 3 == 0) ? 3'b101 : CH'($urandom);
      vid_i = (CH*VW)'($urandom);
      brt_i = BW'($urandom);
      osd_lvl_i = OW'($urandom);
      dc_lvl_i = DW'($urandom);
      step("");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule